// File: doc/BRIEF.md
# AES-128 Round-Serial Decryption Core with Backward Key Derivation

This block recovers a 128-bit plaintext from a 128-bit AES-128 ciphertext. It computes one round per clock. It does not hold an expanded key table. It is given only the final (round-10) round key that the matching encryptor's key expansion produced. From that key it computes each earlier round key in the same cycle that needs it, by running the key expansion backwards.

An external 4-bit counter sets the order of the work through the `round_idx` input:
- Index 0 loads the ciphertext and applies the final key.
- Indices 1 to 9 apply full inverse rounds.
- Index 10 applies the last inverse round, which uses round key 0, and raises the valid flag.

The `run` input is active high. While it is low, the core is held in its cleared state. The core is meant for a 50 MHz system clock; nothing in it depends on that frequency.

Top module: `aes_inv_core`

## Requirements
- R1: While `run` is low at a rising clock edge, `pt_out` becomes all zeros and `pt_valid` becomes 0 after that edge.
- R2: With `run` high and `round_idx` = 0 at an edge, `pt_out` becomes `ct_in` XOR `last_key` after that edge, and `pt_valid` becomes 0.
- R3: With `round_idx` = r in 1..9, the state is updated in this order: inverse ShiftRows, then inverse SubBytes, then XOR with round key 10−r, then inverse MixColumns. Round key 10−r is computed from round key 11−r by the backward key step.
- R4: With `round_idx` = 10, the state is updated by inverse ShiftRows, inverse SubBytes and XOR with round key 0, without inverse MixColumns. `pt_valid` becomes 1 after that edge.
- R5: Take the cipher key 000102030405060708090a0b0c0d0e0f, whose round-10 key is 13111d7fe3944a17f307a78b4d2b30c5. Take the ciphertext 69c4e0d86a7b0430d8cdb78070b4c55a. Indices 0 to 10 applied in order leave `pt_out` = 00112233445566778899aabbccddeeff.
- R6: With `run` high and `round_idx` greater than 10, `pt_out` and `pt_valid` keep their values.
- R7: State layout: byte n of the state occupies bits [127−8n : 120−8n]. Byte n sits in column n/4 and row n%4. A key word j occupies bits [127−32j : 96−32j].
- R8: Backward key step from round key k (k = 10 down to 1):
  - prev word 3 = w3 XOR w2
  - prev word 2 = w2 XOR w1
  - prev word 1 = w1 XOR w0
  - prev word 0 = w0 XOR SubWord(RotWord(prev word 3)) XOR {Rcon(k), 24'h0}
  - Rcon(1) = 01, and each later Rcon is the previous one doubled in GF(2^8).
- R9: `pt_valid` stays 0 after every edge with `round_idx` in 0..9.
- R10: An index of 0 at any point restarts the sequence from the current `ct_in` and `last_key`, whatever rounds ran before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| run | input | 1 | Active-high enable; low clears the core |
| ct_in | input | 128 | Ciphertext block, sampled at index 0 |
| last_key | input | 128 | Round-10 key of the key expansion, sampled at index 0 |
| round_idx | input | 4 | Round index from the external counter |
| pt_out | output | 128 | Working state; the plaintext once `pt_valid` is 1 |
| pt_valid | output | 1 | High after the round that applies key 0 |

## Verification
The known-answer block checks the whole path, including the layout of bytes and words. Random keys and plaintexts are encrypted by a model in the bench, which produces the ciphertext and the round-10 key. Because the bench knows every intermediate encryption state, it predicts `pt_out` after each single round. A wrong byte order, a wrong Rcon or a misplaced inverse MixColumns is therefore pinned to the round where it first shows. Sequences are also aborted midway and restarted, and indices above 10 are applied after a finished block. These cases tell correct reloading and holding apart from state left over from an earlier block.

// File: rtl/aes_inv_pkg.sv
package aes_inv_pkg;

  function automatic logic [7:0] gf_dbl(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_dbl(sh);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254 (0 maps to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] acc;
    sq  = a;
    acc = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq  = gf_mul(sq, sq);
      acc = gf_mul(acc, sq);
    end
    return acc;
  endfunction

  function automatic logic [7:0] affine_fwd(input logic [7:0] a);
    return a ^ {a[6:0], a[7]} ^ {a[5:0], a[7:6]} ^ {a[4:0], a[7:5]}
             ^ {a[3:0], a[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [7:0] affine_inv(input logic [7:0] b);
    return {b[6:0], b[7]} ^ {b[4:0], b[7:5]} ^ {b[1:0], b[7:2]} ^ 8'h05;
  endfunction

  function automatic logic [7:0] sub_fwd(input logic [7:0] x);
    return affine_fwd(gf_inv(x));
  endfunction

  function automatic logic [7:0] sub_inv(input logic [7:0] y);
    return gf_inv(affine_inv(y));
  endfunction

  // round constant for key index k (k >= 1)
  function automatic logic [7:0] rcon_of(input int k);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 1; i < 16; i++) begin
      if (i < k) r = gf_dbl(r);
    end
    return r;
  endfunction

endpackage

// File: rtl/aes_inv_keystep.sv
module aes_inv_keystep
  import aes_inv_pkg::*;
#(
  parameter int BLK    = 128,
  parameter int RIDX_W = 4
) (
  input  logic [BLK-1:0]    key_cur,
  input  logic [RIDX_W-1:0] key_num,
  output logic [BLK-1:0]    key_prev
);
  localparam int NW = BLK / 32;

  logic [31:0] w [NW];
  logic [31:0] p [NW];
  logic [31:0] rot_w;
  logic [31:0] sub_w;
  logic [7:0]  rc;

  for (genvar j = 0; j < NW; j++) begin : g_split
    assign w[j] = key_cur[BLK-1-32*j -: 32];
  end

  for (genvar j = 1; j < NW; j++) begin : g_tail
    assign p[j] = w[j] ^ w[j-1];
  end

  assign rot_w = {p[NW-1][23:0], p[NW-1][31:24]};
  assign rc    = rcon_of(int'(key_num));

  for (genvar b = 0; b < 4; b++) begin : g_sub
    assign sub_w[31-8*b -: 8] = sub_fwd(rot_w[31-8*b -: 8]);
  end

  assign p[0] = w[0] ^ sub_w ^ {rc, 24'h0};

  for (genvar j = 0; j < NW; j++) begin : g_join
    assign key_prev[BLK-1-32*j -: 32] = p[j];
  end

endmodule

// File: rtl/aes_inv_round.sv
module aes_inv_round
  import aes_inv_pkg::*;
#(
  parameter int BLK = 128
) (
  input  logic [BLK-1:0] st_in,
  input  logic [BLK-1:0] rkey,
  input  logic           last_rnd,
  output logic [BLK-1:0] st_out
);
  localparam int NB   = BLK / 8;
  localparam int NCOL = NB / 4;

  logic [7:0] sh  [NB];
  logic [7:0] sb  [NB];
  logic [7:0] ak  [NB];
  logic [7:0] mx  [NB];

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      localparam int DST = c * 4 + r;
      localparam int SRC = ((c - r + NCOL) % NCOL) * 4 + r;
      assign sh[DST] = st_in[BLK-1-8*SRC -: 8];
      assign sb[DST] = sub_inv(sh[DST]);
      assign ak[DST] = sb[DST] ^ rkey[BLK-1-8*DST -: 8];
    end

    assign mx[c*4+0] = gf_mul(ak[c*4+0], 8'h0e) ^ gf_mul(ak[c*4+1], 8'h0b)
                     ^ gf_mul(ak[c*4+2], 8'h0d) ^ gf_mul(ak[c*4+3], 8'h09);
    assign mx[c*4+1] = gf_mul(ak[c*4+0], 8'h09) ^ gf_mul(ak[c*4+1], 8'h0e)
                     ^ gf_mul(ak[c*4+2], 8'h0b) ^ gf_mul(ak[c*4+3], 8'h0d);
    assign mx[c*4+2] = gf_mul(ak[c*4+0], 8'h0d) ^ gf_mul(ak[c*4+1], 8'h09)
                     ^ gf_mul(ak[c*4+2], 8'h0e) ^ gf_mul(ak[c*4+3], 8'h0b);
    assign mx[c*4+3] = gf_mul(ak[c*4+0], 8'h0b) ^ gf_mul(ak[c*4+1], 8'h0d)
                     ^ gf_mul(ak[c*4+2], 8'h09) ^ gf_mul(ak[c*4+3], 8'h0e);
  end

  for (genvar n = 0; n < NB; n++) begin : g_out
    assign st_out[BLK-1-8*n -: 8] = last_rnd ? ak[n] : mx[n];
  end

endmodule

// File: rtl/aes_inv_core.sv
module aes_inv_core #(
  parameter int BLK    = 128,
  parameter int NR     = 10,
  parameter int RIDX_W = 4
) (
  input  logic              clk,
  input  logic              run,
  input  logic [BLK-1:0]    ct_in,
  input  logic [BLK-1:0]    last_key,
  input  logic [RIDX_W-1:0] round_idx,
  output logic [BLK-1:0]    pt_out,
  output logic              pt_valid
);
  localparam logic [RIDX_W-1:0] LAST_IDX = RIDX_W'(NR);

  logic [BLK-1:0]    state_q;
  logic [BLK-1:0]    key_q;
  logic              valid_q;
  logic [BLK-1:0]    ks_src;
  logic [RIDX_W-1:0] ks_num;
  logic [BLK-1:0]    ks_prev;
  logic [BLK-1:0]    rnd_next;

  // named events for the assertions
  logic ev_load;
  logic ev_round;
  logic ev_final;
  logic ev_idle_hold;

  assign ev_load      = run && (round_idx == '0);
  assign ev_round     = run && (round_idx != '0) && (round_idx <= LAST_IDX);
  assign ev_final     = run && (round_idx == LAST_IDX);
  assign ev_idle_hold = run && (round_idx > LAST_IDX);

  assign ks_src = ev_load ? last_key : key_q;
  assign ks_num = ev_load ? LAST_IDX : (LAST_IDX - round_idx);

  aes_inv_keystep #(.BLK(BLK), .RIDX_W(RIDX_W)) u_keystep (
    .key_cur  (ks_src),
    .key_num  (ks_num),
    .key_prev (ks_prev)
  );

  aes_inv_round #(.BLK(BLK)) u_round (
    .st_in    (state_q),
    .rkey     (key_q),
    .last_rnd (ev_final),
    .st_out   (rnd_next)
  );

  always_ff @(posedge clk) begin
    if (!run) begin
      state_q <= '0;
      key_q   <= '0;
      valid_q <= 1'b0;
    end else if (ev_load) begin
      state_q <= ct_in ^ last_key;
      key_q   <= ks_prev;
      valid_q <= 1'b0;
    end else if (ev_round) begin
      state_q <= rnd_next;
      if (!ev_final) key_q <= ks_prev;
      valid_q <= ev_final;
    end
  end

  assign pt_out   = state_q;
  assign pt_valid = valid_q;

  AST_CLEAR_ON_IDLE: assert property (@(posedge clk)
    !run |=> (pt_out == '0 && !pt_valid)); // R1

  AST_LOAD_WHITEN: assert property (@(posedge clk) disable iff (!run)
    ev_load |=> (pt_out == $past(ct_in ^ last_key)) && !pt_valid); // R2

  AST_VALID_AFTER_FINAL: assert property (@(posedge clk) disable iff (!run)
    $rose(pt_valid) |-> $past(round_idx) == LAST_IDX); // R4

  AST_HOLD_BEYOND: assert property (@(posedge clk) disable iff (!run)
    ev_idle_hold |=> $stable(pt_out) && $stable(pt_valid)); // R6

  AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!run)
    (round_idx < LAST_IDX) |=> !pt_valid); // R9

endmodule

// File: tb/aes_inv_core_bench.sv
module aes_inv_core_bench;
  logic         clk = 1'b0;
  logic         run = 1'b0;
  logic [127:0] ct_in = '0;
  logic [127:0] last_key = '0;
  logic [3:0]   round_idx = '0;
  logic [127:0] pt_out;
  logic         pt_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  aes_inv_core u_aes_inv_core (
    .clk(clk), .run(run), .ct_in(ct_in), .last_key(last_key),
    .round_idx(round_idx), .pt_out(pt_out), .pt_valid(pt_valid)
  );

  // ---------- bench model of forward AES-128 ----------
  logic [7:0]   b_sb [256];
  logic [127:0] b_rk [11];
  logic [127:0] b_s  [11];
  logic [127:0] b_ct;

  function automatic logic [7:0] b_x2(input logic [7:0] a);
    logic [7:0] r;
    r = a << 1;
    if (a[7]) r = r ^ 8'h1b;
    return r;
  endfunction

  function automatic logic [7:0] b_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r;
    logic [7:0] t;
    r = 0; t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= t;
      t = b_x2(t);
    end
    return r;
  endfunction

  task automatic build_sbox();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv;
      logic [7:0] o;
      inv = 8'h00;
      for (int j = 1; j < 256; j++)
        if (b_mul(8'(x), 8'(j)) == 8'h01) inv = 8'(j);
      for (int i = 0; i < 8; i++)
        o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
             ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 8'h01) != 0;
      b_sb[x] = o;
    end
  endtask

  function automatic logic [7:0] gb(input logic [127:0] s, input int n);
    return s[127-8*n -: 8];
  endfunction

  function automatic logic [127:0] b_subshift(input logic [127:0] s);
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[127-8*(c*4+r) -: 8] = b_sb[gb(s, ((c + r) % 4) * 4 + r)];
    return o;
  endfunction

  function automatic logic [127:0] b_mix(input logic [127:0] s);
    logic [127:0] o;
    for (int c = 0; c < 4; c++) begin
      logic [7:0] a0, a1, a2, a3;
      a0 = gb(s, c*4); a1 = gb(s, c*4+1); a2 = gb(s, c*4+2); a3 = gb(s, c*4+3);
      o[127-8*(c*4)   -: 8] = b_x2(a0) ^ b_x2(a1) ^ a1 ^ a2 ^ a3;
      o[127-8*(c*4+1) -: 8] = a0 ^ b_x2(a1) ^ b_x2(a2) ^ a2 ^ a3;
      o[127-8*(c*4+2) -: 8] = a0 ^ a1 ^ b_x2(a2) ^ b_x2(a3) ^ a3;
      o[127-8*(c*4+3) -: 8] = b_x2(a0) ^ a0 ^ a1 ^ a2 ^ b_x2(a3);
    end
    return o;
  endfunction

  task automatic b_encrypt(input logic [127:0] key, input logic [127:0] pt);
    logic [31:0] w [44];
    logic [7:0]  rc [10] = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10,
                             8'h20, 8'h40, 8'h80, 8'h1b, 8'h36};
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      logic [31:0] t;
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {b_sb[t[23:16]], b_sb[t[15:8]], b_sb[t[7:0]], b_sb[t[31:24]]};
        t[31:24] ^= rc[i/4 - 1];
      end
      w[i] = w[i-4] ^ t;
    end
    for (int k = 0; k < 11; k++)
      b_rk[k] = {w[4*k], w[4*k+1], w[4*k+2], w[4*k+3]};
    b_s[0] = pt ^ b_rk[0];
    for (int k = 1; k < 10; k++) b_s[k] = b_mix(b_subshift(b_s[k-1])) ^ b_rk[k];
    b_ct = b_subshift(b_s[9]) ^ b_rk[10];
  endtask

  // ---------- checking ----------
  task automatic chk128(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] idx);
    round_idx = idx;
    @(posedge clk);
    @(negedge clk);
  endtask

  // decrypt a block whose model state is in b_s/b_rk/b_ct; d_r = SR(SB(s_{9-r}))
  task automatic run_block(input logic [127:0] pt, input string tag);
    ct_in = b_ct; last_key = b_rk[10]; run = 1'b1;
    step(4'd0);
    chk128({tag, " R2 whiten"}, pt_out, b_ct ^ b_rk[10]);
    chk1({tag, " R9 valid r0"}, pt_valid, 1'b0);
    for (int r = 1; r < 10; r++) begin
      step(4'(r));
      chk128($sformatf("%s R3 R8 round %0d", tag, r), pt_out, b_subshift(b_s[9-r]));
    end
    chk1({tag, " R9 valid r9"}, pt_valid, 1'b0);
    step(4'd10);
    chk128({tag, " R4 plaintext"}, pt_out, pt);
    chk1({tag, " R4 valid"}, pt_valid, 1'b1);
  endtask

  initial begin
    logic [127:0] fk, fp;
    void'($urandom(32'h5eed_a11e));
    build_sbox();
    @(negedge clk);
    step(4'd0);
    chk128("R1 reset state", pt_out, '0);
    chk1("R1 reset valid", pt_valid, 1'b0);

    // known answer (R5, R7)
    fk = 128'h000102030405060708090a0b0c0d0e0f;
    fp = 128'h00112233445566778899aabbccddeeff;
    b_encrypt(fk, fp);
    chk128("R5 model ciphertext", b_ct, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    chk128("R5 model last key", b_rk[10], 128'h13111d7fe3944a17f307a78b4d2b30c5);
    run_block(fp, "R5 R7 kat");

    // R6: indices beyond the last hold everything
    step(4'd11);
    step(4'd15);
    chk128("R6 hold state", pt_out, fp);
    chk1("R6 hold valid", pt_valid, 1'b1);

    // R1: dropping run clears
    run = 1'b0;
    step(4'd3);
    chk128("R1 clear state", pt_out, '0);
    chk1("R1 clear valid", pt_valid, 1'b0);

    // random blocks
    for (int n = 0; n < 20; n++) begin
      logic [127:0] k, p;
      k = {$urandom, $urandom, $urandom, $urandom};
      p = {$urandom, $urandom, $urandom, $urandom};
      if (n == 0) k = '1;
      if (n == 1) p = '0;
      b_encrypt(k, p);
      run_block(p, $sformatf("rand%0d", n));
    end

    // R10: abort midway with a different block, then restart
    for (int n = 0; n < 3; n++) begin
      logic [127:0] k, p;
      k = {$urandom, $urandom, $urandom, $urandom};
      p = {$urandom, $urandom, $urandom, $urandom};
      ct_in = ~ct_in; last_key = {$urandom, $urandom, $urandom, $urandom};
      run = 1'b1;
      step(4'd0);
      for (int r = 1; r <= 4 + n; r++) step(4'(r));
      b_encrypt(k, p);
      run_block(p, $sformatf("R10 restart%0d", n));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule